// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 external interrupt pins, brings each one into the local clock domain and watches it for a condition chosen per line. The condition can be a low level, a high level, a rising edge, a falling edge or either edge. When a line sees its condition, a sticky detect bit is latched for it. Software acknowledges a detection by writing a one to that bit.

A per-line enable mask gates the detect bits onto one interrupt output per line. The mask is changed through two write-one registers: one sets bits and the other clears them. Software can also read the synchronised pin levels and the pending-and-enabled view.

All access goes through a simple 32-bit register port with byte addresses. A write or read strobe lasts a single cycle. Read data is combinational and is valid in the cycle the read strobe is high.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_o` is zero.
- R2: Each pin passes through two flops. A level driven before clock edge k shows at offset 0x104 (bit n = line n) after edge k+1.
- R3: Writing ones at offset 0x08 sets those enable bits. Writing ones at offset 0x04 clears them. Zero bits leave the mask as it was, and reading 0x04 returns the mask.
- R4: Offset 0x00 reads detect AND enable. `irq_o[n]` is high exactly while detect bit n and enable bit n are both set.
- R5: Offset 0x100 reads the detect bits. Writing a one to bit n clears detect bit n, and zero bits are untouched. If a detection and a clear meet in the same cycle, the bit stays set.
- R6: The sense field of line n is the low 6 bits of offset 0x180 + 4·n. Bits 31..6 are not stored and read as zero.
- R7: Code 0x01 detects a low synchronised level and code 0x02 a high one. The detect bit is set again on every cycle the level stays active, even right after a clear.
- R8: Code 0x08 detects a rising edge, 0x04 a falling edge and 0x0C either edge. An edge is the synchronised level differing from its value one cycle earlier. A steady level never sets the bit again.
- R9: A sense field of zero, or any value other than 0x01, 0x02, 0x04, 0x08 or 0x0C, never sets the detect bit.
- R10: A read of any other offset, including misaligned ones and 0x08, returns zero. `rdata` is zero in cycles without `rd_en`. Writes to other offsets, or to the read-only offsets 0x00, 0x100+4 and 0x104, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero without `rd_en` |
| irq_o | output | NUM_LINES | Per-line interrupt, detect AND enable |

## Verification
Suppose a detect bit is corrupted, for example through a wrong sense decode, a wrong clear priority or a bad edge history. The fault shows on `irq_o` in the cycle after the faulty update when the line is enabled. It also shows on any read of 0x100 or 0x00 in that cycle. A bad synchroniser stage appears at 0x104 one edge after the faulty sample. Corruption in the enable or sense storage shows on the next read of 0x04 or 0x180+4·n. Comparing every cycle against a model therefore catches each of these within one or two cycles of the cause.

// File: rtl/extirq_pkg.sv
// Package: shared offsets, sense codes and the sense decode function for
// the external interrupt line controller. Assumes 32-bit data words.
package extirq_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SENSE_W  = 6;

    localparam int unsigned OFS_PEND = 32'h000;
    localparam int unsigned OFS_ENCL = 32'h004;
    localparam int unsigned OFS_ENST = 32'h008;
    localparam int unsigned OFS_DET  = 32'h100;
    localparam int unsigned OFS_LVL  = 32'h104;
    localparam int unsigned OFS_CFG  = 32'h180;

    localparam logic [SENSE_W-1:0] SENSE_LOW  = 6'h01;
    localparam logic [SENSE_W-1:0] SENSE_HIGH = 6'h02;
    localparam logic [SENSE_W-1:0] SENSE_FALL = 6'h04;
    localparam logic [SENSE_W-1:0] SENSE_RISE = 6'h08;
    localparam logic [SENSE_W-1:0] SENSE_BOTH = 6'h0C;

    // Detection condition for one line given its code and level history.
    function automatic logic sense_hit(input logic [SENSE_W-1:0] code,
                                       input logic lvl, input logic prev);
        case (code)
            SENSE_LOW:  return !lvl;
            SENSE_HIGH: return lvl;
            SENSE_FALL: return !lvl && prev;
            SENSE_RISE: return lvl && !prev;
            SENSE_BOTH: return lvl != prev;
            default:    return 1'b0;
        endcase
    endfunction

    // True when the code selects one of the supported modes.
    function automatic logic sense_valid(input logic [SENSE_W-1:0] code);
        return (code == SENSE_LOW) || (code == SENSE_HIGH) || (code == SENSE_FALL) ||
               (code == SENSE_RISE) || (code == SENSE_BOTH);
    endfunction

    // True for the three edge modes.
    function automatic logic sense_edge(input logic [SENSE_W-1:0] code);
        return (code == SENSE_FALL) || (code == SENSE_RISE) || (code == SENSE_BOTH);
    endfunction

endpackage

// File: rtl/extirq_sync.sv
// Module: two-flop synchroniser per pin plus a one-cycle history flop.
// Assumes the pins are asynchronous to clk; lvl is the synchronised level,
// lvl_prev is that level one cycle earlier (used for edge detection).
module extirq_sync #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] lvl,
    output logic [NUM_LINES-1:0] lvl_prev
);

    logic [NUM_LINES-1:0] meta_q;

    // Shift each pin through metastability, level and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= pin_i;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end

endmodule

// File: rtl/extirq_detect.sv
// Module: per-line sense decode and sticky detect bits.
// Assumes cfg_flat holds one SENSE_W field per line (line n at n*SENSE_W).
// A detection in the same cycle as a software clear wins over the clear.
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         lvl,
    input  logic [NUM_LINES-1:0]         lvl_prev,
    input  logic [NUM_LINES*SENSE_W-1:0] cfg_flat,
    input  logic [NUM_LINES-1:0]         det_clr,
    output logic [NUM_LINES-1:0]         det_q
);

    logic [NUM_LINES-1:0] hit;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Decode this line's condition from its sense code.
        assign hit[i] = sense_hit(cfg_flat[i*SENSE_W +: SENSE_W], lvl[i], lvl_prev[i]);
    end

    // Latch detections; clear on write-one, new hits take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= (det_q & ~det_clr) | hit;
    end

endmodule

// File: rtl/extirq_regs.sv
// Module: register decode, enable mask, per-line sense storage and read mux.
// Assumes ADDR_W is wide enough for the last sense register and that
// NUM_LINES is at most 32. Unmapped and misaligned offsets read zero.
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_LINES-1:0]         det_q,
    input  logic [NUM_LINES-1:0]         lvl,
    output logic [DATA_W-1:0]            rdata,
    output logic [NUM_LINES-1:0]         en_q,
    output logic [NUM_LINES*SENSE_W-1:0] cfg_flat,
    output logic [NUM_LINES-1:0]         det_clr
);

    localparam logic [ADDR_W-1:0]   A_PEND   = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0]   A_ENCL   = ADDR_W'(OFS_ENCL);
    localparam logic [ADDR_W-1:0]   A_ENST   = ADDR_W'(OFS_ENST);
    localparam logic [ADDR_W-1:0]   A_DET    = ADDR_W'(OFS_DET);
    localparam logic [ADDR_W-1:0]   A_LVL    = ADDR_W'(OFS_LVL);
    localparam int                  WORD_W   = ADDR_W - 2;
    localparam logic [WORD_W-1:0]   CFG_WBASE = WORD_W'(OFS_CFG / 4);

    logic [SENSE_W-1:0] cfg_q [NUM_LINES];
    logic [WORD_W-1:0]  cfg_word;
    logic               cfg_sel;

    // Word index relative to the first sense register; valid when aligned.
    assign cfg_word = addr[ADDR_W-1:2] - CFG_WBASE;
    assign cfg_sel  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] >= CFG_WBASE) &&
                      (cfg_word < WORD_W'(NUM_LINES));

    // Write-one clear mask for the detect bits.
    assign det_clr = (wr_en && addr == A_DET) ? wdata[NUM_LINES-1:0] : '0;

    // Enable mask: write-one set and write-one clear at separate offsets.
    always_ff @(posedge clk) begin
        if (!rst_n)                     en_q <= '0;
        else if (wr_en && addr == A_ENST) en_q <= en_q | wdata[NUM_LINES-1:0];
        else if (wr_en && addr == A_ENCL) en_q <= en_q & ~wdata[NUM_LINES-1:0];
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
        // Sense field storage for line i; only the low bits are kept.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (wr_en && cfg_sel && cfg_word == WORD_W'(i))
                cfg_q[i] <= wdata[SENSE_W-1:0];
        end
        assign cfg_flat[i*SENSE_W +: SENSE_W] = cfg_q[i];
    end

    // Read multiplexer; zero outside read strobes and for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_PEND)      rdata[NUM_LINES-1:0] = det_q & en_q;
            else if (addr == A_ENCL) rdata[NUM_LINES-1:0] = en_q;
            else if (addr == A_DET)  rdata[NUM_LINES-1:0] = det_q;
            else if (addr == A_LVL)  rdata[NUM_LINES-1:0] = lvl;
            else if (cfg_sel) begin
                for (int i = 0; i < NUM_LINES; i++)
                    if (cfg_word == WORD_W'(i)) rdata[SENSE_W-1:0] = cfg_q[i];
            end
        end
    end

endmodule

// File: rtl/extirq_ctrl.sv
// Module: top of the external interrupt line controller. Ties together the
// synchroniser, the detect logic and the register block, and gates each
// detect bit with its enable to form one interrupt output per line.
// Assumes NUM_LINES <= 32 and a synchronous active-low reset.
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LINES-1:0] irq_o
);

    logic [NUM_LINES-1:0]         lvl;
    logic [NUM_LINES-1:0]         lvl_prev;
    logic [NUM_LINES-1:0]         det_q;
    logic [NUM_LINES-1:0]         det_clr;
    logic [NUM_LINES-1:0]         en_q;
    logic [NUM_LINES*SENSE_W-1:0] cfg_flat;

    extirq_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl(lvl), .lvl_prev(lvl_prev)
    );

    extirq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .lvl_prev(lvl_prev),
        .cfg_flat(cfg_flat), .det_clr(det_clr), .det_q(det_q)
    );

    extirq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .det_q(det_q), .lvl(lvl), .rdata(rdata), .en_q(en_q),
        .cfg_flat(cfg_flat), .det_clr(det_clr)
    );

    // Per-line interrupt: latched detection gated by its enable.
    assign irq_o = det_q & en_q;

endmodule

// File: rtl/extirq_chk.sv
// Module: assertion checker for extirq_ctrl, attached with bind below.
// Observes ports and internal state; drives nothing.
module extirq_chk
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_LINES-1:0]         pin_i,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic [NUM_LINES-1:0]         lvl,
    input logic [NUM_LINES-1:0]         lvl_prev,
    input logic [NUM_LINES-1:0]         det_q,
    input logic [NUM_LINES-1:0]         en_q,
    input logic [NUM_LINES*SENSE_W-1:0] cfg_flat
);

    localparam logic [ADDR_W-1:0] A_ENCL = ADDR_W'(OFS_ENCL);
    localparam logic [ADDR_W-1:0] A_ENST = ADDR_W'(OFS_ENST);
    localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(OFS_DET);

    logic [1:0] since_rst;

    // Count cycles since reset release, saturating, to guard history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: synchronised level is the pin two edges earlier.
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (lvl == $past(pin_i, 2)));

    // R3: set and clear writes take effect on the written bits.
    a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ENST) |=>
        ((en_q & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0])));
    a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ENCL) |=> ((en_q & $past(wdata[NUM_LINES-1:0])) == '0));

    // R10: the mask changes only through its own two offsets.
    a_r10_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_ENST || addr == A_ENCL)) |=> $stable(en_q));

    // R5: detect bits written as zero are kept.
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DET) |=>
        ((det_q & $past(det_q & ~wdata[NUM_LINES-1:0])) ==
         $past(det_q & ~wdata[NUM_LINES-1:0])));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [SENSE_W-1:0] code;
        assign code = cfg_flat[i*SENSE_W +: SENSE_W];

        // R9: unsupported codes never set a clear detect bit.
        a_r9_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense_valid(code) && !det_q[i]) |=> !det_q[i]);

        // R8: in edge modes a steady level does not set the bit.
        a_r8_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_edge(code) && lvl[i] == lvl_prev[i] && !det_q[i]) |=> !det_q[i]);

        // R7: active low level sets the bit next cycle, clear or not.
        a_r7_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (code == SENSE_LOW && !lvl[i]) |=> det_q[i]);
    end

endmodule

bind extirq_ctrl extirq_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .lvl(lvl), .lvl_prev(lvl_prev), .det_q(det_q), .en_q(en_q),
    .cfg_flat(cfg_flat)
);

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 32;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    bit [31:0] m_det, m_en;
    bit [5:0]  m_cfg [NL];
    bit [31:0] hist [$];

    extirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit model_hit(input bit [5:0] c, input bit now, input bit old);
        if (c == 6'h01) return !now;
        if (c == 6'h02) return now;
        if (c == 6'h04) return old && !now;
        if (c == 6'h08) return now && !old;
        if (c == 6'h0C) return now != old;
        return 1'b0;
    endfunction

    function automatic bit [31:0] model_read(input bit r, input bit [11:0] a);
        if (!r) return 32'h0;
        if (a == 12'h000) return m_det & m_en;
        if (a == 12'h004) return m_en;
        if (a == 12'h100) return m_det;
        if (a == 12'h104) return hist[1];
        if (a >= 12'h180 && a < 12'h200 && a[1:0] == 2'b00)
            return {26'h0, m_cfg[(int'(a) - 'h180) / 4]};
        return 32'h0;
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_det = '0; m_en = '0;
            foreach (m_cfg[i]) m_cfg[i] = '0;
            hist = {32'h0, 32'h0, 32'h0};
        end else begin
            bit [31:0] hits = '0;
            for (int n = 0; n < NL; n++)
                hits[n] = model_hit(m_cfg[n], hist[1][n], hist[2][n]);
            if (wr_en && addr == 12'h100) m_det = m_det & ~wdata;
            m_det = m_det | hits;
            if (wr_en && addr == 12'h008) m_en = m_en | wdata;
            if (wr_en && addr == 12'h004) m_en = m_en & ~wdata;
            if (wr_en && addr >= 12'h180 && addr < 12'h200 && addr[1:0] == 2'b00)
                m_cfg[(int'(addr) - 'h180) / 4] = wdata[5:0];
            hist.push_front(pin_i);
            void'(hist.pop_back());
        end
        started = 1'b1;
    end

    // Compare outputs a quarter period after each falling edge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (started) begin
            bit [31:0] e_rd, e_irq;
            e_rd  = model_read(rd_en, addr);
            e_irq = m_det & m_en;
            n_cmp++;
            if (irq_o !== e_irq) begin
                n_bad++;
                $display("FAIL %s irq_o actual=%h expected=%h t=%0t", cur_req, irq_o, e_irq, $time);
            end
            n_cmp++;
            if (rdata !== e_rd) begin
                n_bad++;
                $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", cur_req, addr, rdata, e_rd, $time);
            end
        end
    end

    // Bus tasks: called at a falling edge, hold the strobe for one cycle.
    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input bit [11:0] a);
        rd_en = 1'b1; wr_en = 1'b0; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_all();
        rd(12'h000); rd(12'h004); rd(12'h100); rd(12'h104);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and the outputs
        cur_req = "R1";
        rd_all(); rd(12'h180); rd(12'h1FC); idle(2);

        // R2: pin levels appear at 0x104 after two edges
        cur_req = "R2";
        pin_i = 32'h0000_F0F0;
        rd(12'h104); rd(12'h104); rd(12'h104); rd(12'h104);
        pin_i = 32'h0000_0000;
        rd(12'h104); rd(12'h104); rd(12'h104);

        // R6: only six sense bits stored per line
        cur_req = "R6";
        wr(12'h180, 32'hFFFF_FFC1); rd(12'h180);
        wr(12'h1FC, 32'h0000_003F); rd(12'h1FC);
        wr(12'h1FC, 32'h0000_0000); rd(12'h1FC);

        // R3: enable set and clear at separate offsets
        cur_req = "R3";
        wr(12'h008, 32'h0000_00FF); rd(12'h004);
        wr(12'h004, 32'h0000_000F); rd(12'h004);
        wr(12'h004, 32'h0000_0000); rd(12'h004);
        wr(12'h008, 32'h8000_00FF); rd(12'h004);

        // R7: level modes (line 0 low, line 1 high)
        cur_req = "R7";
        pin_i = 32'h0000_0001;
        wr(12'h184, 32'h02); idle(4); rd_all();
        pin_i = 32'h0000_0002;
        idle(4); rd_all();
        wr(12'h100, 32'h0000_0003); rd(12'h100); rd(12'h100);
        pin_i = 32'h0000_0001;
        idle(4);
        wr(12'h100, 32'h0000_0003); rd(12'h100); rd(12'h000);

        // R5: write-one clear, zero bits untouched, set wins over clear
        cur_req = "R5";
        wr(12'h100, 32'h0000_0001); rd(12'h100);
        pin_i = 32'h0000_0000;
        idle(3);
        wr(12'h100, 32'h0000_0001); rd(12'h100);
        wr(12'h100, 32'h0000_0000); rd(12'h100);
        pin_i = 32'h0000_0001; idle(3);
        wr(12'h100, 32'hFFFF_FFFF); rd(12'h100);

        // R8: edge modes on lines 2 (fall), 3 (rise), 4 (both)
        cur_req = "R8";
        wr(12'h188, 32'h04); wr(12'h18C, 32'h08); wr(12'h190, 32'h0C);
        idle(3); wr(12'h100, 32'h0000_001C); rd(12'h100);
        pin_i = 32'h0000_001D; idle(4); rd_all();
        wr(12'h100, 32'h0000_001C); idle(4); rd(12'h100);
        pin_i = 32'h0000_0001; idle(4); rd_all();
        wr(12'h100, 32'h0000_001C); idle(5); rd(12'h100);

        // R4: pending view and outputs follow detect AND enable
        cur_req = "R4";
        wr(12'h004, 32'h0000_0001); rd(12'h000);
        wr(12'h008, 32'h0000_0001); rd(12'h000);

        // R9: unsupported and zero codes on lines 5, 6, 7, 31
        cur_req = "R9";
        wr(12'h194, 32'h03); wr(12'h198, 32'h10); wr(12'h19C, 32'h00);
        wr(12'h1FC, 32'h3F); wr(12'h008, 32'h8000_00E0);
        for (int k = 0; k < 8; k++) begin
            pin_i = pin_i ^ 32'h8000_00E0;
            idle(2);
        end
        rd_all();

        // R10: unmapped and read-only offsets
        cur_req = "R10";
        wr(12'h00C, 32'hFFFF_FFFF); wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h182, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF); wr(12'h108, 32'hFFFF_FFFF);
        rd(12'h008); rd(12'h00C); rd(12'h182); rd(12'h200); rd(12'h7FC);
        rd(12'h180); rd(12'h184); rd_all();

        // Mixed traffic: random pins, modes, masks and clears
        cur_req = "R4";
        for (int k = 0; k < 3000; k++) begin
            int sel;
            bit [5:0] codes [6] = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h05};
            if ($urandom_range(0, 3) == 0) pin_i = $urandom();
            sel = $urandom_range(0, 6);
            case (sel)
                0: wr(12'h180 + 12'($urandom_range(0, 31) * 4), {26'h0, codes[$urandom_range(0, 5)]});
                1: wr(12'h008, $urandom());
                2: wr(12'h004, $urandom());
                3: wr(12'h100, $urandom());
                4: rd(12'h180 + 12'($urandom_range(0, 31) * 4));
                5: rd(12'($urandom_range(0, 1) * 12'h100 + $urandom_range(0, 1) * 4));
                default: idle(1);
            endcase
        end
        rd_all();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule